// File: doc/BRIEF.md
# 100BASE-X Transmit Code-Group Encoder

This block turns the nibble-wide transmit stream from a MAC into 5-bit code-groups for a 100 Mb/s physical medium, one code-group per 25 MHz symbol clock. A frame begins with a two-symbol start delimiter. The data nibbles follow, each mapped through the 4B/5B table. An error symbol replaces a nibble whenever the MAC flags a transmit error. A two-symbol end delimiter closes the frame, and the idle code fills the gap until the next frame.

Each code-group is XORed with five bits from an 11-bit free-running cipher register before it leaves the block. For media that need no scrambling, a static input bypasses the XOR. The same block derives carrier sense and collision from its own transmit activity and a receive-busy flag supplied by the receive path. Duplex, loopback and collision-test controls act on the collision result. A link-fail flag aborts any frame in progress at once.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tsm` becomes 11111 and `crs` and `col` become 0. The cipher register loads the `CIPHER_SEED` parameter.
- R2: A rising edge of `tx_en` (high now, low in the previous cycle) starts a frame. The start symbol J (11000) is sent, then K (10001). `txd` and `tx_er` have no effect on these two symbols.
- R3: In the data phase, with `tx_er` low, nibble 0..F of `txd` is sent as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Bit 4 is the first bit listed.
- R4: In the data phase, with `tx_en` and `tx_er` both high, H (00100) is sent in place of the mapped nibble.
- R5: The first cycle in the data phase with `tx_en` low sends T (01101), the next cycle sends R (00111), and IDLE (11111) follows until the next start.
- R6: Every cycle out of reset, the register c[11:1] updates. The new c[11:7] is the old c[6:2]. The new c6 is NOR(c11..c2) OR c1. The new c5..c1 are c11^c9, c10^c8, c9^c7, c8^c6 and c7^c5. `tsm[4:0]` is the selected symbol XORed with the new c5..c1, MSB to LSB.
- R7: When `scr_disable` is high, `tsm` carries the unscrambled symbol. The cipher register keeps advancing.
- R8: While `link_fail` is high, the symbol is IDLE and the frame is abandoned. No new frame starts until `tx_en` has been low and rises again.
- R9: In half duplex, with no loopback and no collision test, `col` is high when transmit (`tx_en` high, `link_fail` low) and `rx_busy` are both high.
- R10: With `full_duplex` or `loopback` high and `col_test` low, `col` stays low.
- R11: With `col_test` high, `col` follows `tx_en`.
- R12: `crs` is high when transmit (`tx_en` high, `link_fail` low) or `rx_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable from MAC |
| tx_er | input | 1 | Transmit error from MAC |
| txd | input | 4 | Transmit nibble, bit 0 least significant |
| link_fail | input | 1 | Link down; forces idle |
| scr_disable | input | 1 | Bypass the cipher XOR |
| full_duplex | input | 1 | Full-duplex mode |
| loopback | input | 1 | Loopback mode |
| col_test | input | 1 | Collision test mode |
| rx_busy | input | 1 | Receive path is non-idle |
| tsm | output | 5 | Scrambled transmit code-group |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
Every output is one register away from the inputs. The `tsm`, `crs` and `col` values for inputs presented before a clock edge appear just after that edge. The delimiter sequence itself counts in whole cycles from the `tx_en` edge: J appears one edge after the rise, K one edge after that, and T one edge after the fall. The bench drives inputs on the falling edge and samples on the next falling edge, so each comparison lands exactly one rising edge after its stimulus. It advances its own cipher model once per step, which keeps the model in lockstep with the register.

// File: rtl/txpcs_pkg.sv
// Shared constants and helpers for the transmit code-group encoder.
// Assumes the fixed 4-bit nibble, 5-bit code-group and 11-bit cipher widths
// of 100 Mb/s block coding.
package txpcs_pkg;
    localparam int NIB_W  = 4;
    localparam int SYM_W  = 5;
    localparam int CIPH_W = 11;

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_H    = 5'b00100;
    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

    // Frame phases: idle (may open a frame), K due, data, R due.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_K    = 2'd1,
        PH_DATA = 2'd2,
        PH_R    = 2'd3
    } frame_phase_t;

    // Maps one data nibble to its 5-bit code-group.
    function automatic logic [SYM_W-1:0] nib_to_code(input logic [NIB_W-1:0] n);
        logic [SYM_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/txpcs_framer.sv
// Frame-delimiter state machine and symbol selection.
// Produces the unscrambled code-group for the current cycle from the live
// MAC inputs. A frame opens only on a rising tx_en edge. Link fail wins over
// everything else and returns the machine to idle.
module txpcs_framer
    import txpcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             link_fail,
    output logic [SYM_W-1:0] plain_sym
);
    frame_phase_t phase_q, phase_d;
    logic         en_prev_q;

    // Purpose: remember last cycle's tx_en for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev_q <= 1'b0;
        else        en_prev_q <= tx_en;
    end

    // Purpose: next phase and the symbol to send this cycle.
    always_comb begin
        phase_d   = phase_q;
        plain_sym = SYM_IDLE;
        if (link_fail) begin
            phase_d   = PH_IDLE;
            plain_sym = SYM_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (tx_en && !en_prev_q) begin
                        plain_sym = SYM_J;
                        phase_d   = PH_K;
                    end
                end
                PH_K: begin
                    plain_sym = SYM_K;
                    phase_d   = PH_DATA;
                end
                PH_DATA: begin
                    if (tx_en) begin
                        plain_sym = tx_er ? SYM_H : nib_to_code(txd);
                    end else begin
                        plain_sym = SYM_T;
                        phase_d   = PH_R;
                    end
                end
                default: begin
                    plain_sym = SYM_R;
                    phase_d   = PH_IDLE;
                end
            endcase
        end
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // R2
    j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_sym == SYM_J && !link_fail) |=> (plain_sym == SYM_K || link_fail));

    // R5
    t_then_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_sym == SYM_T && !link_fail) |=> (plain_sym == SYM_R || link_fail));
endmodule

// File: rtl/txpcs_cipher.sv
// 11-bit cipher register, advanced once per symbol.
// The key is the low five bits of the updated value, so the key and the
// register advance in the same cycle. The NOR term pulls the register out of
// the all-zero state. Assumes a nonzero seed.
module txpcs_cipher
    import txpcs_pkg::*;
#(
    parameter logic [CIPH_W-1:0] SEED = 11'h5A5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SYM_W-1:0] key
);
    logic [CIPH_W:1] c_q, c_d;

    // Purpose: one step of the cipher recurrence.
    always_comb begin
        c_d[11:7] = c_q[6:2];
        c_d[6]    = ~(|c_q[11:2]) | c_q[1];
        c_d[5]    = c_q[11] ^ c_q[9];
        c_d[4]    = c_q[10] ^ c_q[8];
        c_d[3]    = c_q[9]  ^ c_q[7];
        c_d[2]    = c_q[8]  ^ c_q[6];
        c_d[1]    = c_q[7]  ^ c_q[5];
        key       = c_d[5:1];
    end

    // Purpose: cipher state register.
    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= SEED;
        else        c_q <= c_d;
    end

    // R6
    cipher_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q != '0);
endmodule

// File: rtl/txpcs_carrier.sv
// Carrier-sense and collision outputs, registered so that they line up with
// the code-group. Transmit counts as active while tx_en is high and the link
// is up.
module txpcs_carrier (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic link_fail,
    input  logic rx_busy,
    input  logic full_duplex,
    input  logic loopback,
    input  logic col_test,
    output logic crs,
    output logic col
);
    logic tx_live;
    logic col_d;

    // Purpose: transmit activity and collision decision.
    always_comb begin
        tx_live = tx_en && !link_fail;
        if (col_test)                      col_d = tx_en;
        else if (full_duplex || loopback)  col_d = 1'b0;
        else                               col_d = tx_live && rx_busy;
    end

    // Purpose: output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crs <= 1'b0;
            col <= 1'b0;
        end else begin
            crs <= tx_live || rx_busy;
            col <= col_d;
        end
    end
endmodule

// File: rtl/pcs_tx_encoder.sv
// Top of the transmit code-group encoder. It selects the symbol, XORs it
// with the cipher key unless bypassed, and registers the result, together
// with carrier sense and collision. Every output lags its inputs by one clock.
module pcs_tx_encoder
    import txpcs_pkg::*;
#(
    parameter logic [CIPH_W-1:0] CIPHER_SEED = 11'h5A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             link_fail,
    input  logic             scr_disable,
    input  logic             full_duplex,
    input  logic             loopback,
    input  logic             col_test,
    input  logic             rx_busy,
    output logic [SYM_W-1:0] tsm,
    output logic             crs,
    output logic             col
);
    logic [SYM_W-1:0] plain_sym;
    logic [SYM_W-1:0] key;

    txpcs_framer i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .txd       (txd),
        .link_fail (link_fail),
        .plain_sym (plain_sym)
    );

    txpcs_cipher #(.SEED(CIPHER_SEED)) i_cipher (
        .clk   (clk),
        .rst_n (rst_n),
        .key   (key)
    );

    txpcs_carrier i_carrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .link_fail   (link_fail),
        .rx_busy     (rx_busy),
        .full_duplex (full_duplex),
        .loopback    (loopback),
        .col_test    (col_test),
        .crs         (crs),
        .col         (col)
    );

    // Purpose: symbol output register with optional scrambling.
    always_ff @(posedge clk) begin
        if (!rst_n) tsm <= SYM_IDLE;
        else        tsm <= scr_disable ? plain_sym : (plain_sym ^ key);
    end

    // R8
    lf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fail && scr_disable) |=> (tsm == SYM_IDLE));

    // R10
    col_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((full_duplex || loopback) && !col_test) |=> !col);

    // R12
    crs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> crs);
endmodule

// File: tb/test_pcs_tx_encoder.sv
module test_pcs_tx_encoder;
    localparam logic [10:0] SEED = 11'h5A5;
    localparam logic [4:0] C_J = 5'b11000, C_K = 5'b10001, C_T = 5'b01101,
                           C_R = 5'b00111, C_H = 5'b00100, C_I = 5'b11111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, er = 0, lf = 0, scr = 1, fdx = 0, lpbk = 0, ctst = 0, rx = 0;
    logic [3:0] d = 4'h0;
    logic [4:0] tsm;
    logic crs, col;
    logic [11:1] mc;
    int checks = 0;
    int errors = 0;

    logic [4:0] code_tab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                  5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                  5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                  5'b11010, 5'b11011, 5'b11100, 5'b11101};

    always #10 clk = ~clk;

    pcs_tx_encoder #(.CIPHER_SEED(SEED)) i_pcs_tx_encoder (
        .clk(clk), .rst_n(rst_n), .tx_en(en), .tx_er(er), .txd(d),
        .link_fail(lf), .scr_disable(scr), .full_duplex(fdx), .loopback(lpbk),
        .col_test(ctst), .rx_busy(rx), .tsm(tsm), .crs(crs), .col(col));

    function automatic logic [11:1] cnext(input logic [11:1] c);
        logic [11:1] r;
        r[11:7] = c[6:2];
        r[6] = ~(|c[11:2]) | c[1];
        r[5] = c[11] ^ c[9];
        r[4] = c[10] ^ c[8];
        r[3] = c[9] ^ c[7];
        r[2] = c[8] ^ c[6];
        r[1] = c[7] ^ c[5];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One clock: inputs already set at a falling edge; compare at the next one.
    task automatic step(input logic [4:0] plain, input string tag);
        logic [11:1] nc;
        logic [4:0] exp_sym;
        logic exp_crs, exp_col;
        string ctag;
        nc = cnext(mc);
        mc = nc;
        exp_sym = scr ? plain : (plain ^ nc[5:1]);
        exp_crs = (en && !lf) || rx;
        if (ctst) begin exp_col = en; ctag = "R11"; end
        else if (fdx || lpbk) begin exp_col = 1'b0; ctag = "R10"; end
        else begin exp_col = en && !lf && rx; ctag = "R9"; end
        @(negedge clk);
        chk(tsm === exp_sym, tag, tsm, exp_sym);
        chk(crs === exp_crs, "R12", {4'b0, crs}, {4'b0, exp_crs});
        chk(col === exp_col, ctag, {4'b0, col}, {4'b0, exp_col});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tsm === C_I, "R1", tsm, C_I);
        chk(crs === 1'b0, "R1", {4'b0, crs}, 5'b0);
        chk(col === 1'b0, "R1", {4'b0, col}, 5'b0);
        rst_n = 1'b1;
        mc = SEED;
    endtask

    // Frame of len random nibbles; tx_er high for index range [es, es+el), J at -2, K at -1.
    task automatic send_frame(input int len, input int es, input int el);
        for (int i = -2; i < len; i++) begin
            en = 1'b1;
            d  = 4'($urandom);
            er = (i >= es && i < es + el);
            if (i == -2)      step(C_J, "R2");
            else if (i == -1) step(C_K, "R2");
            else if (er)      step(C_H, "R4");
            else              step(code_tab[d], "R3");
        end
        en = 1'b0; er = 1'b0;
        step(C_T, "R5");
        step(C_R, "R5");
        for (int i = 0; i < 3; i++) step(C_I, "R5");
    endtask

    task automatic t_plain_frames();
        scr = 1'b1;
        send_frame(16, 100, 0);
        send_frame(9, -2, 2);
        send_frame(12, 3, 4);
    endtask

    task automatic t_cipher();
        scr = 1'b0;
        for (int i = 0; i < 8; i++) step(C_I, "R6");
        send_frame(20, 5, 2);
        scr = 1'b1;
        for (int i = 0; i < 4; i++) step(C_I, "R7");
    endtask

    task automatic t_linkfail();
        scr = 1'b1;
        en = 1'b1; d = 4'h3;
        step(C_J, "R2");
        step(C_K, "R2");
        step(code_tab[3], "R3");
        lf = 1'b1; d = 4'h7;
        step(C_I, "R8");
        step(C_I, "R8");
        lf = 1'b0;
        step(C_I, "R8");
        step(C_I, "R8");
        en = 1'b0;
        step(C_I, "R8");
        send_frame(4, 100, 0);
        scr = 1'b0;
        en = 1'b1; lf = 1'b1;
        step(C_I, "R8");
        lf = 1'b0; en = 1'b0;
        step(C_I, "R8");
    endtask

    task automatic t_collision();
        scr = 1'b1;
        rx = 1'b1;
        send_frame(5, 100, 0);
        fdx = 1'b1;
        send_frame(5, 100, 0);
        fdx = 1'b0; lpbk = 1'b1;
        send_frame(5, 100, 0);
        lpbk = 1'b0; rx = 1'b0; ctst = 1'b1;
        send_frame(5, 100, 0);
        fdx = 1'b1;
        send_frame(3, 100, 0);
        fdx = 1'b0; ctst = 1'b0;
        step(C_I, "R12");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_plain_frames();
        t_cipher();
        t_linkfail();
        t_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule